// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block runs one external memory access at a time for a small processor. A request carries a 22-bit address, a read/write flag and a write byte. It is accepted only while the controller is idle. Each access then passes through an address phase and a data phase. In the address phase the active-low address strobe is low. The low address byte goes out on a shared byte bus, and the upper address bits go out on dedicated outputs. In the data phase the active-low data strobe is low, and the shared bus either carries the write byte or is released so that read data can be sampled.

Each phase can be lengthened in two ways. The first is a programmed number of extra clocks. There are two sets of settings, and address bit 21 picks between them: one for the lower block and one for the upper block. The second is an active-low wait input, honoured only while its enable input is set. One clock after the data strobe rises, a single-clock done pulse reports the end of the access, and the captured read byte is presented with it.

Top module: `membus_cycle`

## Requirements
- R1: After reset, both strobes and the read/write line are high, the bus enable and done are low, and every wait setting is at its maximum. A lower-block access then holds the address strobe low for 4 clocks and the data strobe low for 8 clocks.
- R2: An accepted request starts the address phase on the next clock. The address strobe is low for 1+AS clocks. The data strobe falls in the clock in which the address strobe rises and stays low for 1+DS clocks. The two strobes are never low together.
- R3: The AS and DS settings come from the upper-block fields when address bit 21 is 1, and from the lower-block fields when it is 0.
- R4: While the address strobe is low, the bus carries address bits 7:0 with the bus enable high. For the whole access the high-address output carries bits 15:8 and the segment output carries bits 21:16.
- R5: For the whole access the read/write line is 1 for a read and 0 for a write. Outside an access it rests at 1.
- R6: During the data phase of a write, the bus enable is high and the bus carries the write byte. Outside an access the bus enable is low.
- R7: During the data phase of a read, the bus enable is low. The bus input is captured at the clock edge on which the data strobe rises.
- R8: Done is high for exactly one clock, namely the clock after the data strobe rises, with both strobes high. The read output holds the captured byte until the next read completes.
- R9: With the wait enable set, each clock edge at which the wait input is sampled low adds one clock to the phase in progress at that edge.
- R10: With the wait enable clear, the wait input has no effect on either phase length.
- R11: A request presented while an access is in progress is ignored. No further access starts after the done pulse.
- R12: A configuration load takes all four wait fields at once. The settings used by an access are fixed at acceptance, so a load during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Load the four wait fields |
| cfgAsLo | input | 2 | Extra address-phase clocks, lower block |
| cfgAsHi | input | 2 | Extra address-phase clocks, upper block |
| cfgDsLo | input | 3 | Extra data-phase clocks, lower block |
| cfgDsHi | input | 3 | Extra data-phase clocks, upper block |
| waitEn | input | 1 | Honour the wait input |
| reqValid | input | 1 | Access request, taken when idle |
| reqAddr | input | 22 | Access address |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 8 | Write byte |
| waitN | input | 1 | Active-low external wait |
| busIn | input | 8 | Shared bus input value |
| busOut | output | 8 | Shared bus output value |
| busOe | output | 1 | Shared bus drive enable |
| asN | output | 1 | Active-low address strobe |
| dsN | output | 1 | Active-low data strobe |
| rwN | output | 1 | Read (1) / write (0) line |
| addrHi | output | 8 | Address bits 15:8 |
| addrSeg | output | 6 | Address bits 21:16 |
| rdData | output | 8 | Captured read byte |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
A phase counter or state that is wrong shows up as a strobe that is low for the wrong number of clocks. It is visible within the same access, at the rising edge of that strobe, and the bench measures it against 1+setting+sampled waits. A wrong choice of block bank shows as the lower-block length appearing on an upper-block access. A capture taken one clock early or late returns a byte that is off by one, because the bench changes the bus input every data-phase clock. A corrupted data-path latch shows as a wrong address byte or write byte during the strobes of the same access.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic addrPhase;
    logic dataPhase;
    logic capture;
    logic donePulse;
  } ctrlStrb_t;
endpackage

// File: rtl/membus_cfg.sv
module membus_cfg #(
  parameter int AS_W = 2,
  parameter int DS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic [AS_W-1:0] cfgAsLo,
  input  logic [AS_W-1:0] cfgAsHi,
  input  logic [DS_W-1:0] cfgDsLo,
  input  logic [DS_W-1:0] cfgDsHi,
  output logic [AS_W-1:0] asLo,
  output logic [AS_W-1:0] asHi,
  output logic [DS_W-1:0] dsLo,
  output logic [DS_W-1:0] dsHi
);
  // reset leaves every field at its largest value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asLo <= '1;
      asHi <= '1;
      dsLo <= '1;
      dsHi <= '1;
    end else if (cfgLoad) begin
      asLo <= cfgAsLo;
      asHi <= cfgAsHi;
      dsLo <= cfgDsLo;
      dsHi <= cfgDsHi;
    end
  end
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int AS_W = 2,
  parameter int DS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqUpper,
  input  logic            waitEn,
  input  logic            waitN,
  input  logic [AS_W-1:0] asLo,
  input  logic [AS_W-1:0] asHi,
  input  logic [DS_W-1:0] dsLo,
  input  logic [DS_W-1:0] dsHi,
  output logic            asN,
  output logic            dsN,
  output ctrlStrb_t       strb
);
  localparam int CNT_W = (AS_W > DS_W) ? AS_W : DS_W;

  busState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [DS_W-1:0]  dsHold;
  logic             stall;
  logic             cntZero;

  assign stall   = waitEn & ~waitN;
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      dsHold <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_ADDR;
            cnt    <= CNT_W'(reqUpper ? asHi : asLo);
            dsHold <= reqUpper ? dsHi : dsLo;
          end
        end
        ST_ADDR: begin
          if (!stall) begin
            if (cntZero) begin
              state <= ST_DATA;
              cnt   <= CNT_W'(dsHold);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (!stall) begin
            if (cntZero) state <= ST_FIN;
            else         cnt   <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchReq  = (state == ST_IDLE) & reqValid;
    strb.addrPhase = (state == ST_ADDR);
    strb.dataPhase = (state == ST_DATA);
    strb.capture   = (state == ST_DATA) & cntZero & ~stall;
    strb.donePulse = (state == ST_FIN);
  end

  assign asN = ~(state == ST_ADDR);
  assign dsN = ~(state == ST_DATA);
endmodule

// File: rtl/membus_dpath.sv
module membus_dpath
  import membus_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWrite,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        busIn,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  output logic                     rwN,
  output logic [DATA_W-1:0]        addrHi,
  output logic [ADDR_W-2*DATA_W-1:0] addrSeg,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done
);
  localparam int SEG_W = ADDR_W - 2 * DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic              active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strb.latchReq) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rdQ <= '0;
    else if (strb.capture && !writeQ) rdQ <= busIn;
  end

  assign active  = strb.addrPhase | strb.dataPhase;
  assign busOut  = strb.addrPhase ? addrQ[DATA_W-1:0] : wdataQ;
  assign busOe   = strb.addrPhase | (strb.dataPhase & writeQ);
  assign rwN     = ~(active & writeQ);
  assign addrHi  = addrQ[2*DATA_W-1:DATA_W];
  assign addrSeg = addrQ[ADDR_W-1 -: SEG_W];
  assign rdData  = rdQ;
  assign done    = strb.donePulse;
endmodule

// File: rtl/membus_cycle.sv
module membus_cycle
  import membus_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8,
  parameter int AS_W   = 2,
  parameter int DS_W   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgLoad,
  input  logic [AS_W-1:0]            cfgAsLo,
  input  logic [AS_W-1:0]            cfgAsHi,
  input  logic [DS_W-1:0]            cfgDsLo,
  input  logic [DS_W-1:0]            cfgDsHi,
  input  logic                       waitEn,
  input  logic                       reqValid,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       reqWrite,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic                       waitN,
  input  logic [DATA_W-1:0]          busIn,
  output logic [DATA_W-1:0]          busOut,
  output logic                       busOe,
  output logic                       asN,
  output logic                       dsN,
  output logic                       rwN,
  output logic [DATA_W-1:0]          addrHi,
  output logic [ADDR_W-2*DATA_W-1:0] addrSeg,
  output logic [DATA_W-1:0]          rdData,
  output logic                       done
);
  localparam int BLK_BIT = ADDR_W - 1;

  ctrlStrb_t       strb;
  logic [AS_W-1:0] asLo, asHi;
  logic [DS_W-1:0] dsLo, dsHi;

  membus_cfg #(.AS_W(AS_W), .DS_W(DS_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgAsLo(cfgAsLo), .cfgAsHi(cfgAsHi), .cfgDsLo(cfgDsLo), .cfgDsHi(cfgDsHi),
    .asLo(asLo), .asHi(asHi), .dsLo(dsLo), .dsHi(dsHi)
  );

  membus_ctrl #(.AS_W(AS_W), .DS_W(DS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUpper(reqAddr[BLK_BIT]),
    .waitEn(waitEn), .waitN(waitN),
    .asLo(asLo), .asHi(asHi), .dsLo(dsLo), .dsHi(dsHi),
    .asN(asN), .dsN(dsN), .strb(strb)
  );

  membus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .rwN(rwN), .addrHi(addrHi),
    .addrSeg(addrSeg), .rdData(rdData), .done(done)
  );
endmodule

// File: rtl/membus_chk.sv
module membus_chk (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic dsN,
  input logic rwN,
  input logic busOe,
  input logic done
);
  // R2: strobes never overlap
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!asN && !dsN));
  // R2: data strobe is low in the clock the address strobe rises
  p_ds_follows_as_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) |-> !dsN);
  // R5: read/write line steady across the access
  p_rw_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && $past(!asN)) |-> $stable(rwN));
  // R6: write data phase drives the bus
  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && !rwN) |-> busOe);
  // R6: bus released outside an access
  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (asN && dsN) |-> !busOe);
  // R7: read data phase leaves the bus released
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && rwN) |-> !busOe);
  // R8: done follows the data strobe and lasts one clock
  p_done_after_ds_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(!dsN));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind membus_cycle membus_chk u_membus_chk (
  .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .rwN(rwN),
  .busOe(busOe), .done(done)
);

// File: tb/test_membus_cycle.sv
module test_membus_cycle;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [1:0]  cfgAsLo = '0, cfgAsHi = '0;
  logic [2:0]  cfgDsLo = '0, cfgDsHi = '0;
  logic        waitEn = 1'b0;
  logic        reqValid = 1'b0;
  logic [21:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqWdata = '0;
  logic        waitN = 1'b1;
  logic [7:0]  busIn = '0;
  logic [7:0]  busOut;
  logic        busOe, asN, dsN, rwN, done;
  logic [7:0]  addrHi, rdData;
  logic [5:0]  addrSeg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  membus_cycle i_membus_cycle (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgAsLo(cfgAsLo), .cfgAsHi(cfgAsHi), .cfgDsLo(cfgDsLo), .cfgDsHi(cfgDsHi),
    .waitEn(waitEn), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .waitN(waitN), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .asN(asN), .dsN(dsN), .rwN(rwN),
    .addrHi(addrHi), .addrSeg(addrSeg), .rdData(rdData), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic load_cfg(input int al, input int ah, input int dl, input int dh);
    @(negedge clk);
    cfgAsLo = 2'(al); cfgAsHi = 2'(ah); cfgDsLo = 3'(dl); cfgDsHi = 3'(dh);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // One access; expAs/expDs are the programmed extra clocks expected in use.
  // poke: present a second request and a config load mid-access (R11, R12).
  task automatic access(input logic [21:0] a, input bit wr, input logic [7:0] wd,
                        input int expAs, input int expDs, input logic [31:0] mask,
                        input bit wen, input bit poke);
    int asC = 0, dsC = 0, lowA = 0, lowD = 0, idx = 0;
    bit addrBad = 0, dataBad = 0, rwBad = 0, orderBad = 0, gotDone = 0;
    logic [7:0] heldRd;
    @(negedge clk);
    reqAddr = a; reqWrite = wr; reqWdata = wd; reqValid = 1'b1;
    waitEn = wen; waitN = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = ~a; reqWdata = ~wd; reqWrite = ~wr;
    while (idx < 200) begin
      if (done) begin gotDone = 1; break; end
      if (!asN && !dsN) orderBad = 1;
      if (!asN) begin
        asC++;
        if (dsC != 0) orderBad = 1;
        if (!(busOe && busOut == a[7:0] && addrHi == a[15:8] && addrSeg == a[21:16]))
          addrBad = 1;
        if (rwN != !wr) rwBad = 1;
      end else if (!dsN) begin
        dsC++;
        if (busOe != wr || (wr && busOut != wd) ||
            addrHi != a[15:8] || addrSeg != a[21:16]) dataBad = 1;
        if (rwN != !wr) rwBad = 1;
      end else begin
        orderBad = 1;
      end
      waitN = ~mask[idx % 32];
      if (wen && mask[idx % 32]) begin
        if (!asN) lowA++; else lowD++;
      end
      busIn = 8'h40 + 8'(dsC);
      if (poke && idx == 1) begin
        reqValid = 1'b1; reqAddr = 22'h0000AA;
        cfgAsLo = 2'd0; cfgAsHi = 2'd0; cfgDsLo = 3'd0; cfgDsHi = 3'd0;
        cfgLoad = 1'b1;
      end else begin
        reqValid = 1'b0; cfgLoad = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    waitN = 1'b1;
    chk(gotDone, "R8", "done seen", int'(gotDone), 1);
    chk(!orderBad, "R2", "phase order", int'(orderBad), 0);
    chk(asC == 1 + expAs + lowA, (wen ? "R9" : (a[21] ? "R3" : "R2")),
        "address strobe clocks", asC, 1 + expAs + lowA);
    chk(dsC == 1 + expDs + lowD, (wen ? "R9" : "R10"),
        "data strobe clocks", dsC, 1 + expDs + lowD);
    chk(!addrBad, "R4", "address on bus", int'(addrBad), 0);
    chk(!rwBad, "R5", "read/write line", int'(rwBad), 0);
    if (wr) chk(!dataBad, "R6", "write data phase", int'(dataBad), 0);
    else begin
      chk(!dataBad, "R7", "read data phase release", int'(dataBad), 0);
      chk(rdData == 8'h40 + 8'(1 + expDs + lowD), "R7", "captured byte",
          int'(rdData), 8'h40 + 1 + expDs + lowD);
    end
    chk(asN && dsN && !busOe && rwN, "R8", "strobes high at done",
        int'({asN, dsN, busOe, rwN}), 4'b1101);
    heldRd = rdData;
    @(negedge clk);
    chk(!done, "R8", "done width", int'(done), 0);
    chk(rdData == heldRd, "R8", "read byte held", int'(rdData), int'(heldRd));
    if (poke) begin
      bit started = 0;
      for (int k = 0; k < 4; k++) begin
        if (!asN || !dsN || done) started = 1;
        @(negedge clk);
      end
      chk(!started, "R11", "no access from busy request", int'(started), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(asN && dsN && rwN && !busOe && !done, "R1", "reset outputs",
        int'({asN, dsN, rwN, busOe, done}), 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    // R1: default wait settings at maximum
    access(22'h012345, 1'b0, 8'h00, 3, 7, 32'h0, 1'b0, 1'b0);
    access(22'h2ABCDE, 1'b1, 8'h5A, 3, 7, 32'h0, 1'b0, 1'b0);

    // R3: sweep every setting for both blocks, reads and writes
    for (int as = 0; as < 4; as++) begin
      for (int ds = 0; ds < 8; ds++) begin
        load_cfg(as, 3 - as, ds, 7 - ds);
        for (int blk = 0; blk < 2; blk++) begin
          for (int wr = 0; wr < 2; wr++) begin
            logic [21:0] a;
            a = {1'(blk), 5'(as * 8 + ds), 8'(ds * 29 + 3), 8'(as * 61 + wr)};
            // R10: wait input toggles while disabled
            access(a, 1'(wr), 8'(as * 16 + ds + 8'h81),
                   blk ? 3 - as : as, blk ? 7 - ds : ds,
                   32'hA5A5_5A5A, 1'b0, 1'b0);
          end
        end
      end
    end

    // R9: external waits in either phase
    load_cfg(1, 0, 2, 3);
    access(22'h001122, 1'b0, 8'h00, 1, 2, 32'h0000_0001, 1'b1, 1'b0);
    access(22'h001122, 1'b1, 8'h3C, 1, 2, 32'h0000_0006, 1'b1, 1'b0);
    access(22'h203344, 1'b0, 8'h00, 0, 3, 32'h0000_00F0, 1'b1, 1'b0);
    access(22'h203344, 1'b1, 8'hC3, 0, 3, 32'h0000_0155, 1'b1, 1'b0);
    access(22'h005566, 1'b0, 8'h00, 1, 2, 32'h0000_0FFF, 1'b1, 1'b0);

    // R11, R12: request and config load during an access
    load_cfg(2, 2, 5, 5);
    access(22'h00BEEF, 1'b0, 8'h00, 2, 5, 32'h0, 1'b0, 1'b1);
    // R12: the load made mid-access now applies
    access(22'h00BEEF, 1'b0, 8'h00, 0, 0, 32'h0, 1'b0, 1'b0);
    access(22'h20BEEF, 1'b1, 8'h77, 0, 0, 32'h0, 1'b0, 1'b0);

    finish_run();
  end
endmodule